// File: doc/BRIEF.md
# Halt Timer Freeze Control

This block holds a small per-timer control word in the debug domain. For every timer it decides whether that timer keeps counting while a debugger has halted the processor core. When a timer's stop bit is set and the core is halted, the block drops that timer's synchronous count enable and raises that timer's output-disable line. When the core runs, or the stop bit is clear, the timer counts and drives its outputs normally.

The control word lives at one word address on a 32-bit peripheral bus and accepts only full-word accesses. Only power-on reset clears it. System reset leaves it intact and does not block writes, so a debugger can set up freezing before the system leaves reset. The halt indication comes from another clock domain and passes through a two-flop synchronizer before it gates anything.

Top module: `halt_freeze_ctl`

## Requirements
- R1: While power-on reset (`por_i`, synchronous, active high) is asserted, the control word clears to zero, `bus_ready_o` and `bus_rdata_o` go to zero, every bit of `cnt_en_o` goes high and every bit of `out_dis_o` goes low.
- R2: Asserting `sys_rst_i` does not change the control word.
- R3: A full-word write to the register address while `sys_rst_i` is high updates the control word in the same way as a write outside system reset.
- R4: Only accesses with `bus_size_i` = 2'b10 (word) act on the register. Byte (2'b00), halfword (2'b01) and code 2'b11 writes leave the control word unchanged, and such reads return zero.
- R5: Only address 0xE004200C is decoded. A write to any other address leaves the control word unchanged, and a read of any other address returns zero.
- R6: Bit 0 controls timer 1. Bits 2, 3 and 4 control timers 15, 16 and 17. Bit 1 and bits 31:5 always read zero and ignore written values. Lane 1 of `cnt_en_o` and `out_dis_o` is never frozen.
- R7: A timer whose stop bit is 0 keeps its `cnt_en_o` lane high and its `out_dis_o` lane low, halted or not.
- R8: While the synchronized halt is high, a timer whose stop bit is 1 has its `cnt_en_o` lane low and its `out_dis_o` lane high.
- R9: `halt_i` passes through two flops. Gating begins on the second rising clock edge after `halt_i` rises and ends on the second rising clock edge after it falls, with no further latency.
- R10: `bus_ready_o` is high for exactly the one cycle that follows each cycle in which `bus_sel_i` is high. In that cycle a decoded word read presents the control word as it stood before the request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_i | input | 1 | System reset; has no effect on the control word |
| halt_i | input | 1 | Core halted indication, asynchronous to clk_i |
| bus_sel_i | input | 1 | Access request, one access per cycle it is high |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address of the access |
| bus_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 invalid |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while bus_ready_o is high |
| bus_ready_o | output | 1 | Access completion, one cycle per request |
| cnt_en_o | output | 5 | Per-timer synchronous count enable, indexed by control bit |
| out_dis_o | output | 5 | Per-timer output disable, indexed by control bit |

## Verification
A bus write to the control word and the rise of the synchronized halt can fall on the same clock edge. The bench provokes this by raising `halt_i` one cycle before it issues a word write, so the write and the second synchronizer stage take effect together. It then judges that the enables right after that edge already follow the new stop bits and not the old ones. A second overlap, a write issued while system reset is held, is judged by reading the new value back during reset and again after reset is released.

// File: rtl/hfz_pkg.sv
package hfz_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned STOP_W     = 5;
    localparam int unsigned SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] REG_ADDR  = 32'hE004_200C;
    // Implemented stop bits: 0 (timer 1), 2, 3, 4 (timers 15..17); bit 1 reserved
    localparam logic [STOP_W-1:0] IMPL_MASK = 5'b11101;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] widen(input logic [STOP_W-1:0] v);
        return {{(DATA_W-STOP_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/hfz_sync.sv
module hfz_sync #(
    parameter int unsigned STAGES = hfz_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hfz_regs.sv
module hfz_regs
    import hfz_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = REG_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_rst,
    input  bus_req_t          req,
    output logic [STOP_W-1:0] stop_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o
);
    logic              hit;
    logic              word_ok;
    logic              wr_fire;
    logic              rd_fire;
    logic [STOP_W-1:0] stop_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ready_q;

    assign hit     = req.sel && (req.addr == BASE);
    assign word_ok = (req.size == SZ_WORD);
    assign wr_fire = hit && word_ok && req.wr;
    assign rd_fire = hit && word_ok && !req.wr;

    // Control word: cleared by power-on reset only, system reset is not a term here
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= '0;
        end else if (wr_fire) begin
            stop_q <= req.wdata[STOP_W-1:0] & IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= req.sel;
            rdata_q <= rd_fire ? widen(stop_q) : '0;
        end
    end

    assign stop_o  = stop_q;
    assign rdata_o = rdata_q;
    assign ready_o = ready_q;

    assert_sysrst_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && !wr_fire) |=> $stable(stop_q));

    assert_write_in_sysrst_R3: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && wr_fire) |=> (widen(stop_q) == ($past(req.wdata) & widen(IMPL_MASK))));

    assert_narrow_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (req.sel && req.size != SZ_WORD) |=> ($stable(stop_q) && rdata_q == '0));

    assert_miss_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (req.sel && req.addr != BASE) |=> ($stable(stop_q) && rdata_q == '0));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rdata_q & ~widen(IMPL_MASK)) == '0);

    assert_ready_after_req_R10: assert property (@(posedge clk) disable iff (rst)
        req.sel |=> ready_q);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req.sel |=> !ready_q);

endmodule

// File: rtl/hfz_gate.sv
module hfz_gate
    import hfz_pkg::*;
#(
    parameter logic [STOP_W-1:0] MASK = IMPL_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halted,
    input  logic [STOP_W-1:0] stop,
    output logic [STOP_W-1:0] cnt_en,
    output logic [STOP_W-1:0] out_dis
);
    for (genvar i = 0; i < STOP_W; i++) begin : g_lane
        logic freeze;
        assign freeze     = halted && stop[i] && MASK[i];
        assign cnt_en[i]  = !freeze;
        assign out_dis[i] = freeze;

        assert_clear_bit_runs_R7: assert property (@(posedge clk) disable iff (rst)
            !stop[i] |-> (cnt_en[i] && !out_dis[i]));
    end

    assert_running_core_free_R7: assert property (@(posedge clk) disable iff (rst)
        !halted |-> (&cnt_en && out_dis == '0));

endmodule

// File: rtl/halt_freeze_ctl.sv
module halt_freeze_ctl
    import hfz_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = REG_ADDR
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              sys_rst_i,
    input  logic              halt_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_ready_o,
    output logic [STOP_W-1:0] cnt_en_o,
    output logic [STOP_W-1:0] out_dis_o
);
    bus_req_t          req;
    logic              halt_s;
    logic [STOP_W-1:0] stop;

    assign req.sel   = bus_sel_i;
    assign req.wr    = bus_wr_i;
    assign req.addr  = bus_addr_i;
    assign req.size  = acc_size_e'(bus_size_i);
    assign req.wdata = bus_wdata_i;

    hfz_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk_i),
        .rst (por_i),
        .d   (halt_i),
        .q   (halt_s)
    );

    hfz_regs #(.BASE(BASE)) u_regs (
        .clk     (clk_i),
        .rst     (por_i),
        .sys_rst (sys_rst_i),
        .req     (req),
        .stop_o  (stop),
        .rdata_o (bus_rdata_o),
        .ready_o (bus_ready_o)
    );

    hfz_gate #(.MASK(IMPL_MASK)) u_gate (
        .clk     (clk_i),
        .rst     (por_i),
        .halted  (halt_s),
        .stop    (stop),
        .cnt_en  (cnt_en_o),
        .out_dis (out_dis_o)
    );

    // Cycles since power-on reset, saturating at the synchronizer depth
    logic [1:0] since_por_q;
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            since_por_q <= '0;
        end else if (since_por_q != 2'(SYNC_DEPTH)) begin
            since_por_q <= since_por_q + 2'd1;
        end
    end

    assert_por_clears_R1: assert property (@(posedge clk_i)
        $past(por_i) |-> (stop == '0 && !bus_ready_o && bus_rdata_o == '0));

    assert_sync_delay_R9: assert property (@(posedge clk_i) disable iff (por_i)
        (since_por_q == 2'(SYNC_DEPTH)) |-> (halt_s == $past(halt_i, SYNC_DEPTH)));

    assert_frozen_when_halted_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (halt_s && stop[0]) |-> (!cnt_en_o[0] && out_dis_o[0]));

    assert_reserved_lane_free_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (cnt_en_o[1] && !out_dis_o[1]));

endmodule

// File: tb/halt_freeze_ctl_test.sv
module halt_freeze_ctl_test;

    localparam logic [31:0] ADR = 32'hE004_200C;

    typedef struct packed {
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 9;
    // Each vector: write, then word read-back of the register; register state carries over
    localparam vec_t VECS [NV] = '{
        '{2'b10, ADR,            32'hFFFF_FFFF, 32'h0000_001D},
        '{2'b00, ADR,            32'h0000_0000, 32'h0000_001D},
        '{2'b01, ADR,            32'h0000_0000, 32'h0000_001D},
        '{2'b11, ADR,            32'h0000_0000, 32'h0000_001D},
        '{2'b10, ADR + 32'd4,    32'h0000_0000, 32'h0000_001D},
        '{2'b10, ADR,            32'h0000_0002, 32'h0000_0000},
        '{2'b10, ADR,            32'hFFFF_FFE5, 32'h0000_0005},
        '{2'b10, 32'hE004_2008,  32'h0000_001F, 32'h0000_0005},
        '{2'b10, ADR,            32'h0000_0018, 32'h0000_0018}
    };

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        sys_rst = 1'b0;
    logic        halt = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;
    logic [4:0]  cnt_en;
    logic [4:0]  out_dis;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    halt_freeze_ctl uut (
        .clk_i       (clk),
        .por_i       (por),
        .sys_rst_i   (sys_rst),
        .halt_i      (halt),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_size_i  (size),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .bus_ready_o (ready),
        .cnt_en_o    (cnt_en),
        .out_dis_o   (out_dis)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sampled at the next rising edge,
    // response observed at the following falling edge
    task automatic access(input logic w, input logic [31:0] a, input logic [1:0] s,
                          input logic [31:0] d, output logic [31:0] rd, output logic rdy);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; size = s; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd  = rdata;
        rdy = ready;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        logic [31:0] rd;
        logic        rdy;
        access(1'b0, ADR, 2'b10, '0, rd, rdy);
        check(req, {31'd0, rdy}, 32'd1);
        check(req, rd, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic        rdy;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while power-on reset is held
        check("R1 ready in reset", {31'd0, ready}, 32'd0);
        check("R1 rdata in reset", rdata, 32'd0);
        check("R1 cnt_en in reset", {27'd0, cnt_en}, 32'h1F);
        check("R1 out_dis in reset", {27'd0, out_dis}, 32'h0);
        por = 1'b0;
        read_word("R1 word after reset", 32'h0);

        // Vector table: R4 sizes, R5 decode, R6 reserved bits
        for (int i = 0; i < NV; i++) begin
            access(1'b1, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, rdy);
            check($sformatf("R10 ready on write vector %0d", i), {31'd0, rdy}, 32'd1);
            read_word($sformatf("R4/R5/R6 vector %0d", i), VECS[i].expv);
        end

        // R10: ready drops after the single response cycle
        @(posedge clk);
        @(negedge clk);
        check("R10 ready idle", {31'd0, ready}, 32'd0);

        // R5 / R4: reads that do not decode return zero but still complete
        access(1'b0, ADR + 32'd8, 2'b10, '0, rd, rdy);
        check("R5 miss read data", rd, 32'h0);
        check("R10 miss read ready", {31'd0, rdy}, 32'd1);
        access(1'b0, ADR, 2'b00, '0, rd, rdy);
        check("R4 byte read data", rd, 32'h0);

        // Halt with control word 0x18 (timers 16, 17 stopped)
        @(negedge clk);
        halt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 one edge after halt", {27'd0, cnt_en}, 32'h1F);
        @(posedge clk);
        @(negedge clk);
        check("R8 cnt_en halted", {27'd0, cnt_en}, 32'h07);
        check("R8 out_dis halted", {27'd0, out_dis}, 32'h18);
        check("R7 clear bits run", {31'd0, cnt_en[0] & cnt_en[2]}, 32'd1);

        access(1'b1, ADR, 2'b10, 32'h0000_001F, rd, rdy);
        check("R8 cnt_en after write", {27'd0, cnt_en}, 32'h02);
        check("R6 lane 1 never frozen", {27'd0, out_dis}, 32'h1D);

        @(negedge clk);
        halt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 one edge after release", {27'd0, cnt_en}, 32'h02);
        @(posedge clk);
        @(negedge clk);
        check("R9 two edges after release", {27'd0, cnt_en}, 32'h1F);
        check("R9 outputs back", {27'd0, out_dis}, 32'h0);

        // System reset: holds value, stays writable
        @(negedge clk);
        sys_rst = 1'b1;
        repeat (3) @(posedge clk);
        read_word("R2 held through system reset", 32'h1D);
        access(1'b1, ADR, 2'b10, 32'h0000_0004, rd, rdy);
        read_word("R3 written during system reset", 32'h04);
        @(negedge clk);
        sys_rst = 1'b0;
        @(posedge clk);
        read_word("R2 after system reset release", 32'h04);

        // Same-edge overlap: write lands on the edge the synchronized halt rises
        @(negedge clk);
        halt = 1'b1;
        access(1'b1, ADR, 2'b10, 32'h0000_0001, rd, rdy);
        check("R8 overlap cnt_en", {27'd0, cnt_en}, 32'h1E);
        check("R8 overlap out_dis", {27'd0, out_dis}, 32'h01);

        // Power-on reset again while halted
        @(negedge clk);
        por = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 cnt_en during second reset", {27'd0, cnt_en}, 32'h1F);
        por = 1'b0;
        read_word("R1 word after second reset", 32'h0);
        check("R7 zero word while halted", {27'd0, cnt_en}, 32'h1F);
        halt = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule